// File: doc/BRIEF.md
# Load-Store Address Alignment and Byte Merge Unit

This unit sits between a core's register read stage and a synchronous data memory. Each request carries a base register value, a signed 16-bit displacement, an operation code and a byte-order select. In the same cycle the unit adds the sign-extended displacement to the base and presents the word-aligned memory address. It also drives the byte-lane enables and the read or write strobe. A word access with a nonzero low address, or a halfword access with an odd address, is not performed: it raises an address-error flag and touches neither memory nor the register file.

For loads, the aligned memory word returns one clock later. The unit then extracts a byte or halfword, sign- or zero-extended, or passes the whole word. It also implements a left and a right partial-word load. Each of these reads only bytes inside one aligned word and merges them with the old destination register value, so two such loads in sequence assemble a word from an unaligned address. The byte-order select chooses whether the lowest-addressed byte is the most or the least significant byte of a word.

Top module: `ldst_align`

## Requirements
- R1: `mem_addr` equals `base` plus the sign-extended `offset`, with its two low bits forced to 0.
- R2: For word load (op 4) and word store (op 10), an effective address with low bits other than 00 raises `addr_err` in the same cycle. In that case `mem_be` is 0, `mem_rd` and `mem_wr` stay low, and no writeback follows. An aligned word access enables all four lanes, and the word load returns `rdata` unchanged.
- R3: Halfword ops (2, 3, 9) with address bit 0 set raise `addr_err` and are suppressed as in R2. Byte ops (0, 1, 8) and the partial loads (5, 6) never raise it.
- R4: A byte load reads the byte at offset a within the word. With `big_end`=1 it is lane 3-a, and with `big_end`=0 it is lane a, where lane k is `rdata[8k+7:8k]`. Op 0 sign-extends the byte and op 1 zero-extends it.
- R5: A halfword load at offset a reads the bytes at a and a+1. With `big_end`=1 the byte at a is the upper byte, and with `big_end`=0 it is the lower byte. Op 2 sign-extends the result and op 3 zero-extends it.
- R6: Left partial load (op 5), with `big_end`=1, places the bytes at a..3 into the register from the top byte down. With `big_end`=0 it places the bytes at 0..a into the top bytes, with byte a in the highest. In both cases the remaining low bytes keep `old_rd`.
- R7: Right partial load (op 6), with `big_end`=1, places the bytes at 0..a into the register so that byte a lands in the lowest byte. With `big_end`=0 it places the bytes at a..3 from the lowest byte up. In both cases the remaining high bytes keep `old_rd`.
- R8: `mem_be` sets exactly the lanes of the bytes the access touches, each byte at offset k mapping to lane 3-k or lane k according to `big_end`. This holds for byte, halfword and word stores and for all loads.
- R9: A performed load (`mem_rd`=1) gives `wb_valid`=1 on the next cycle, with `wb_data` computed from that cycle's `rdata`. Otherwise `wb_valid`=0.
- R10: While `rst_n` is low, `wb_valid` is 0.
- R11: Op codes 7 and 11 to 15, and any cycle with `req_valid`=0, produce no strobe, no lane enable, no error and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| op | input | 4 | Operation code |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| old_rd | input | 32 | Current destination register value |
| rdata | input | 32 | Aligned memory word, one cycle after the read |
| big_end | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_err | output | 1 | Misaligned access exception |
| wb_valid | output | 1 | Load result valid |
| wb_data | output | 32 | Load result for the register file |

## Verification
The hardest case to bring about from the ports is a partial load whose merged result shows both halves of its source. This means byte positions from `rdata` next to bytes kept from `old_rd`, at every one of the four offsets and in both byte orders. The stimulus sweeps every offset for each byte order with distinct old values and fresh memory words. A suppressed writeback is only visible in the cycle after a misaligned load, so faulting requests are placed directly before idle and valid cycles. A long random stream then mixes every op code, including undefined ones, with back-to-back loads.

// File: rtl/ldst_align.sv
module ldst_align (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [3:0]  op,
  input  logic [31:0] base,
  input  logic [15:0] offset,
  input  logic [31:0] old_rd,
  input  logic [31:0] rdata,
  input  logic        big_end,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        addr_err,
  output logic        wb_valid,
  output logic [31:0] wb_data
);
  localparam logic [3:0] OP_LB = 4'd0, OP_LBU = 4'd1, OP_LH = 4'd2, OP_LHU = 4'd3,
                         OP_LW = 4'd4, OP_LWL = 4'd5, OP_LWR = 4'd6,
                         OP_SB = 4'd8, OP_SH = 4'd9, OP_SW = 4'd10;

  logic [31:0] ea;
  logic [1:0]  a, s;
  logic        is_ld, is_st, sz_b, sz_h, sz_w, mis;
  logic [3:0]  be_raw;

  assign ea    = base + {{16{offset[15]}}, offset};
  assign a     = ea[1:0];
  assign is_ld = op inside {OP_LB, OP_LBU, OP_LH, OP_LHU, OP_LW, OP_LWL, OP_LWR};
  assign is_st = op inside {OP_SB, OP_SH, OP_SW};
  assign sz_b  = op inside {OP_LB, OP_LBU, OP_SB};
  assign sz_h  = op inside {OP_LH, OP_LHU, OP_SH};
  assign sz_w  = op inside {OP_LW, OP_SW};
  assign mis   = (sz_w && a != 2'b00) || (sz_h && a[0]);
  assign s     = big_end ? a : ~a;

  always_comb begin
    be_raw = 4'b0000;
    if (sz_b)              be_raw = 4'b0001 << (big_end ? ~a : a);
    else if (sz_h)         be_raw = (big_end ^ a[1]) ? 4'b1100 : 4'b0011;
    else if (sz_w)         be_raw = 4'b1111;
    else if (op == OP_LWL) be_raw = 4'b1111 >> s;
    else if (op == OP_LWR) be_raw = 4'b1111 << ~s;
  end

  assign addr_err = req_valid && (is_ld || is_st) && mis;
  assign mem_rd   = req_valid && is_ld && !mis;
  assign mem_wr   = req_valid && is_st && !mis;
  assign mem_be   = (mem_rd || mem_wr) ? be_raw : 4'b0000;
  assign mem_addr = {ea[31:2], 2'b00};

  logic [3:0]  q_op;
  logic [1:0]  q_a;
  logic        q_big;
  logic [31:0] q_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      q_op     <= '0;
      q_a      <= '0;
      q_big    <= 1'b0;
      q_old    <= '0;
    end else begin
      wb_valid <= mem_rd;
      if (mem_rd) begin
        q_op  <= op;
        q_a   <= a;
        q_big <= big_end;
        q_old <= old_rd;
      end
    end
  end

  logic [1:0]  ql, qs;
  logic [7:0]  bsel;
  logic [15:0] hsel;

  assign ql   = q_big ? ~q_a : q_a;
  assign bsel = 8'(rdata >> {ql, 3'b000});
  assign hsel = (q_big ^ q_a[1]) ? rdata[31:16] : rdata[15:0];
  assign qs   = q_big ? q_a : ~q_a;

  always_comb begin
    case (q_op)
      OP_LB:   wb_data = {{24{bsel[7]}}, bsel};
      OP_LBU:  wb_data = {24'b0, bsel};
      OP_LH:   wb_data = {{16{hsel[15]}}, hsel};
      OP_LHU:  wb_data = {16'b0, hsel};
      OP_LWL:  wb_data = (rdata << {qs, 3'b000}) |
                         (q_old & ~(32'hFFFF_FFFF << {qs, 3'b000}));
      OP_LWR:  wb_data = (rdata >> {~qs, 3'b000}) |
                         (q_old & ~(32'hFFFF_FFFF >> {~qs, 3'b000}));
      default: wb_data = rdata;
    endcase
  end
endmodule

module ldst_align_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] op,
  input logic [3:0] mem_be,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_err,
  input logic       wb_valid
);
  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (mem_be == 4'b0000 && !mem_rd && !mem_wr));

  p_byte_never_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op inside {4'd0, 4'd1, 4'd8}) |-> (!addr_err && $countones(mem_be) == 1));

  p_word_all_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op == 4'd4 || op == 4'd10) && !addr_err) |-> (mem_be == 4'hF));

  p_wb_follows_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> wb_valid);

  p_wb_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_rd));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_be == 4'b0000 && !addr_err && !mem_rd && !mem_wr));
endmodule

bind ldst_align ldst_align_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .mem_be(mem_be),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_err(addr_err), .wb_valid(wb_valid)
);

// File: tb/ldst_align_tb_top.sv
`timescale 1ns/1ps
module ldst_align_tb_top;
  logic clk = 0, rst_n = 0, req_valid = 0, big_end = 0;
  logic [3:0] op = 0;
  logic [31:0] base = 0, old_rd = 0, rdata = 0;
  logic [15:0] offset = 0;
  logic [31:0] mem_addr, wb_data;
  logic [3:0] mem_be;
  logic mem_rd, mem_wr, addr_err, wb_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  logic p_v = 0, p_bg = 0;
  logic [3:0] p_op = 0;
  logic [1:0] p_a = 0;
  logic [31:0] p_old = 0;

  always #5 clk = ~clk;

  ldst_align dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .base(base),
    .offset(offset), .old_rd(old_rd), .rdata(rdata), .big_end(big_end), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_err(addr_err),
    .wb_valid(wb_valid), .wb_data(wb_data));

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R4";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd10: return "R2";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd8, 4'd9: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic void model_req(input logic v, input logic [3:0] o, input logic [31:0] b,
      input logic [15:0] off, input logic bg, output logic [31:0] e, output logic [3:0] be,
      output logic rd, output logic wr, output logic er);
    int lo, hi, ai;
    logic ld, st;
    e = b + 32'($signed(off));
    ai = int'(e[1:0]);
    lo = 0; hi = -1; er = 0;
    case (o)
      4'd0, 4'd1, 4'd8: begin lo = ai; hi = ai; end
      4'd2, 4'd3, 4'd9: begin lo = ai; hi = ai + 1; er = e[0]; end
      4'd4, 4'd10:      begin lo = 0; hi = 3; er = (ai != 0); end
      4'd5: if (bg) begin lo = ai; hi = 3; end else begin lo = 0; hi = ai; end
      4'd6: if (bg) begin lo = 0; hi = ai; end else begin lo = ai; hi = 3; end
      default: ;
    endcase
    ld = (o <= 4'd6);
    st = (o >= 4'd8 && o <= 4'd10);
    er = v && (ld || st) && er;
    rd = v && ld && !er;
    wr = v && st && !er;
    be = 4'b0000;
    if (rd || wr)
      for (int k = lo; k <= hi; k++) be[bg ? 3 - k : k] = 1'b1;
  endfunction

  function automatic logic [31:0] model_wb(input logic [3:0] o, input logic [1:0] a,
      input logic bg, input logic [31:0] old, input logic [31:0] w);
    logic [7:0] mb[4];
    logic [7:0] r[4];
    logic [15:0] h;
    int ai;
    ai = int'(a);
    for (int k = 0; k < 4; k++) begin
      mb[k] = bg ? w[8*(3-k) +: 8] : w[8*k +: 8];
      r[k] = old[8*k +: 8];
    end
    h = bg ? {mb[ai], mb[(ai+1)%4]} : {mb[(ai+1)%4], mb[ai]};
    case (o)
      4'd0: return {{24{mb[ai][7]}}, mb[ai]};
      4'd1: return {24'b0, mb[ai]};
      4'd2: return {{16{h[15]}}, h};
      4'd3: return {16'b0, h};
      4'd5: begin
        if (bg) for (int i = 0; i <= 3 - ai; i++) r[3-i] = mb[ai+i];
        else    for (int j = 0; j <= ai; j++) r[3-ai+j] = mb[j];
        return {r[3], r[2], r[1], r[0]};
      end
      4'd6: begin
        if (bg) for (int j = 0; j <= ai; j++) r[ai-j] = mb[j];
        else    for (int i = ai; i <= 3; i++) r[i-ai] = mb[i];
        return {r[3], r[2], r[1], r[0]};
      end
      default: return bg ? {mb[0], mb[1], mb[2], mb[3]} : {mb[3], mb[2], mb[1], mb[0]};
    endcase
  endfunction

  task automatic step(input logic v, input logic [3:0] o, input logic [31:0] b,
      input logic [15:0] off, input logic [31:0] old, input logic bg);
    logic [31:0] e;
    logic [3:0] be;
    logic rd, wr, er;
    @(negedge clk);
    req_valid = v; op = o; base = b; offset = off; old_rd = old; big_end = bg;
    rdata = $urandom;
    #4;
    model_req(v, o, b, off, bg, e, be, rd, wr, er);
    if (v) chk("R1", "mem_addr", mem_addr, {e[31:2], 2'b00});
    chk(tag_of(o), "mem_be", {28'b0, mem_be}, {28'b0, be});
    chk(tag_of(o), "mem_rd", {31'b0, mem_rd}, {31'b0, rd});
    chk(tag_of(o), "mem_wr", {31'b0, mem_wr}, {31'b0, wr});
    chk((o == 4'd2 || o == 4'd3 || o == 4'd9) ? "R3" : "R2", "addr_err", {31'b0, addr_err}, {31'b0, er});
    chk("R9", "wb_valid", {31'b0, wb_valid}, {31'b0, p_v});
    if (p_v) chk(tag_of(p_op), "wb_data", wb_data, model_wb(p_op, p_a, p_bg, p_old, rdata));
    @(posedge clk);
    p_v = rd; p_op = o; p_a = e[1:0]; p_bg = bg; p_old = old;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      req_valid = 1; op = 4'd4; base = 32'h100; rdata = $urandom;
      #4 chk("R10", "wb_valid in reset", {31'b0, wb_valid}, 32'd0);
    end
    @(negedge clk);
    req_valid = 0;
    rst_n = 1;
    #4 chk("R10", "wb_valid after reset", {31'b0, wb_valid}, 32'd0);

    step(1, 4'd4, 32'h0000_1000, 16'h0004, 32'h1111_1111, 1);
    step(1, 4'd4, 32'h0000_1001, 16'h0000, 32'h2222_2222, 1);
    step(0, 4'd0, 32'h0, 16'h0, 32'h0, 0);
    step(1, 4'd10, 32'h0000_1000, 16'h0002, 32'h0, 0);
    step(1, 4'd2, 32'h0000_1000, 16'h0001, 32'h0, 1);
    step(1, 4'd3, 32'h0000_1000, 16'h0002, 32'h0, 0);
    step(1, 4'd0, 32'h0000_1003, 16'h0000, 32'h0, 1);
    step(1, 4'd1, 32'h0000_1003, 16'h0000, 32'h0, 0);
    step(1, 4'd4, 32'h0000_2000, 16'hFFFC, 32'h0, 0);
    step(1, 4'd7, 32'h0000_2000, 16'h0000, 32'h0, 0);
    for (int bg = 0; bg < 2; bg++)
      for (int a = 0; a < 4; a++) begin
        step(1, 4'd5, 32'h0000_3000 + a, 16'h0000, 32'hA5C3_5A3C, bg[0]);
        step(1, 4'd6, 32'h0000_3000 + a, 16'h0000, 32'h1234_5678, bg[0]);
        step(1, 4'd8, 32'h0000_3000 + a, 16'h0000, 32'h0, bg[0]);
        step(1, 4'd9, 32'h0000_3000 + a, 16'h0000, 32'h0, bg[0]);
        step(1, 4'd0, 32'h0000_3000 + a, 16'h0000, 32'h0, bg[0]);
        step(1, 4'd2, 32'h0000_3000 + a, 16'h0000, 32'h0, bg[0]);
      end
    for (int n = 0; n < 3000; n++)
      step(($urandom % 8) != 0, 4'($urandom), $urandom, 16'($urandom), $urandom, 1'($urandom));
    step(0, 4'd0, 32'h0, 16'h0, 32'h0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule